// File: doc/BRIEF.md
# Mailbox Channel Handshake Engine

This block keeps the state bytes of a one-deep mailbox shared by a host and a coprocessor. There are seven outbound channels (host to coprocessor) and seven inbound channels (coprocessor to host). Each channel carries a two-bit handshake state that both sides update through their own write ports. The block accepts only the moves that the handshake allows. It keeps one bitmap of outbound channels that hold a finished reply and one bitmap of inbound channels that hold a fresh message. It raises one interrupt for each bitmap and rings a doorbell toward the coprocessor when the host hands work over.

On an outbound channel the host is the poster and the coprocessor is the server. On an inbound channel the two roles swap. A poster may move a channel from IDLE to NEW, and later from COMPLETE back to IDLE. A server may move it from NEW to RCVD, and then from RCVD to COMPLETE. The reply is written back into the request's buffer before COMPLETE is set. The buffer contents are held elsewhere and this block does not touch them.

Top module: `mbox_hs_engine`

## Requirements
- R1: After reset every channel state reads IDLE, both bitmaps are zero, and int_send, int_recv, doorbell and proto_err are low.
- R2: Outbound channel (dir=0). The state codes are IDLE=0, NEW=1, RCVD=2 and COMPLETE=3. A host write of 1 is applied from 0. A coprocessor write of 2 is applied from 1. A coprocessor write of 3 is applied from 2. A host write of 0 is applied from 3.
- R3: Inbound channel (dir=1). A coprocessor write of 1 is applied from 0. A host write of 2 is applied from 1. A host write of 3 is applied from 2. A coprocessor write of 0 is applied from 3.
- R4: Bit i of send_done_map is 1 exactly while outbound channel i is COMPLETE. int_send is the OR of that map.
- R5: Bit i of recv_new_map is 1 exactly while inbound channel i is NEW. int_recv is the OR of that map.
- R6: A write whose value is greater than 3, or whose channel number is 7 or above, is ignored. No state changes, no error is flagged and no doorbell rings.
- R7: A write that carries a legal code but is not a move allowed for the writing side from the current state leaves the state unchanged. It sets proto_err, which stays high until reset.
- R8: doorbell is high for exactly one cycle, the cycle after an applied host write of NEW or COMPLETE. Coprocessor writes and host writes of IDLE or RCVD never ring it.
- R9: Host and coprocessor writes in the same cycle to different channels are both applied.
- R10: rd_state shows the state of the channel picked by rd_dir and rd_ch, with no added latency. A write becomes visible in it from the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host state write strobe |
| h_dir | input | 1 | Host write direction, 0 outbound, 1 inbound |
| h_ch | input | 3 | Host write channel |
| h_val | input | 8 | Host state byte value |
| c_we | input | 1 | Coprocessor state write strobe |
| c_dir | input | 1 | Coprocessor write direction |
| c_ch | input | 3 | Coprocessor write channel |
| c_val | input | 8 | Coprocessor state byte value |
| rd_dir | input | 1 | Read direction select |
| rd_ch | input | 3 | Read channel select |
| rd_state | output | 2 | State of the selected channel |
| send_done_map | output | 7 | Outbound channels in COMPLETE |
| recv_new_map | output | 7 | Inbound channels in NEW |
| int_send | output | 1 | Outbound completion interrupt |
| int_recv | output | 1 | Inbound arrival interrupt |
| doorbell | output | 1 | One-cycle ring toward the coprocessor |
| proto_err | output | 1 | Sticky illegal-transition flag |

## Verification
If a channel holds a wrong state, it shows up one edge later in three places: rd_state, a bit of a bitmap and an interrupt level. If a transition is wrongly accepted or refused, the next read shows a state that is one step off. It may also show a proto_err that rises or fails to rise on that same edge. A doorbell decode fault shows up as a pulse that is missing, extra or longer than one cycle, right after the host write. The bench therefore checks every output one cycle after each write. It walks both directions through their full cycles, interleaved across channels, before it tries illegal and ignored writes.

// File: rtl/mbox_hs_engine.sv
module mbox_hs_engine #(
  parameter int NCH = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       h_we,
  input  logic                       h_dir,
  input  logic [$clog2(NCH+1)-1:0]   h_ch,
  input  logic [7:0]                 h_val,
  input  logic                       c_we,
  input  logic                       c_dir,
  input  logic [$clog2(NCH+1)-1:0]   c_ch,
  input  logic [7:0]                 c_val,
  input  logic                       rd_dir,
  input  logic [$clog2(NCH+1)-1:0]   rd_ch,
  output logic [1:0]                 rd_state,
  output logic [NCH-1:0]             send_done_map,
  output logic [NCH-1:0]             recv_new_map,
  output logic                       int_send,
  output logic                       int_recv,
  output logic                       doorbell,
  output logic                       proto_err
);

  localparam int CW = $clog2(NCH+1);
  localparam logic [CW-1:0] LAST = CW'(NCH-1);
  localparam logic [1:0] IDLE = 2'd0, NEW = 2'd1, RCVD = 2'd2, DONE = 2'd3;

  logic [1:0] s_st [NCH];
  logic [1:0] r_st [NCH];

  function automatic logic legal(input logic poster, input logic [1:0] cur, input logic [1:0] nxt);
    if (poster) return (cur == IDLE && nxt == NEW) || (cur == DONE && nxt == IDLE);
    else        return (cur == NEW && nxt == RCVD) || (cur == RCVD && nxt == DONE);
  endfunction

  logic       h_ok, c_ok, h_go, c_go, h_bad, c_bad;
  logic [1:0] h_cur, c_cur;

  assign h_ok  = h_we && (h_ch <= LAST) && (h_val < 8'd4);
  assign c_ok  = c_we && (c_ch <= LAST) && (c_val < 8'd4);
  assign h_cur = (h_ch <= LAST) ? (h_dir ? r_st[h_ch] : s_st[h_ch]) : IDLE;
  assign c_cur = (c_ch <= LAST) ? (c_dir ? r_st[c_ch] : s_st[c_ch]) : IDLE;
  assign h_go  = h_ok &&  legal(!h_dir, h_cur, h_val[1:0]);
  assign c_go  = c_ok &&  legal(c_dir, c_cur, c_val[1:0]);
  assign h_bad = h_ok && !legal(!h_dir, h_cur, h_val[1:0]);
  assign c_bad = c_ok && !legal(c_dir, c_cur, c_val[1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_st[i] <= IDLE;
        r_st[i] <= IDLE;
      end else begin
        if (h_go && !h_dir && h_ch == CW'(i)) s_st[i] <= h_val[1:0];
        if (c_go && !c_dir && c_ch == CW'(i)) s_st[i] <= c_val[1:0];
        if (h_go &&  h_dir && h_ch == CW'(i)) r_st[i] <= h_val[1:0];
        if (c_go &&  c_dir && c_ch == CW'(i)) r_st[i] <= c_val[1:0];
      end
    end
    assign send_done_map[i] = (s_st[i] == DONE);
    assign recv_new_map[i]  = (r_st[i] == NEW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doorbell  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      doorbell  <= h_go && (h_val[1:0] == NEW || h_val[1:0] == DONE);
      proto_err <= proto_err | h_bad | c_bad;
    end
  end

  assign int_send = |send_done_map;
  assign int_recv = |recv_new_map;
  assign rd_state = (rd_ch <= LAST) ? (rd_dir ? r_st[rd_ch] : s_st[rd_ch]) : IDLE;

  p_doorbell_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(h_we) && ($past(h_val) == 8'd1 || $past(h_val) == 8'd3));

  p_send_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_send) |-> $past(c_we && !c_dir && c_val == 8'd3));

  p_recv_new_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_recv) |-> $past(c_we && c_dir && c_val == 8'd1));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_we && !c_we) |=> $stable(send_done_map) && $stable(recv_new_map));

  p_bell_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell || $past(h_we));

endmodule

// File: tb/mbox_hs_engine_bench.sv
module mbox_hs_engine_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0, h_dir = 1'b0, c_we = 1'b0, c_dir = 1'b0, rd_dir = 1'b0;
  logic [2:0] h_ch = '0, c_ch = '0, rd_ch = '0;
  logic [7:0] h_val = '0, c_val = '0;
  logic [1:0] rd_state;
  logic [6:0] send_done_map, recv_new_map;
  logic int_send, int_recv, doorbell, proto_err;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mbox_hs_engine u_mbox_hs_engine (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_dir(h_dir), .h_ch(h_ch), .h_val(h_val),
    .c_we(c_we), .c_dir(c_dir), .c_ch(c_ch), .c_val(c_val),
    .rd_dir(rd_dir), .rd_ch(rd_ch), .rd_state(rd_state),
    .send_done_map(send_done_map), .recv_new_map(recv_new_map),
    .int_send(int_send), .int_recv(int_recv),
    .doorbell(doorbell), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [3:0] req;
    logic hwe; logic hdir; logic [2:0] hch; logic [7:0] hval;
    logic cwe; logic cdir; logic [2:0] cch; logic [7:0] cval;
    logic rdd; logic [2:0] rdc; logic [1:0] est;
    logic [6:0] esm; logic [6:0] erm; logic edb; logic eerr;
  } vec_t;

  function automatic vec_t mk(int req, bit hwe, bit hdir, int hch, int hval,
                              bit cwe, bit cdir, int cch, int cval,
                              bit rdd, int rdc, int est, logic [6:0] esm,
                              logic [6:0] erm, bit edb, bit eerr);
    vec_t v;
    v.req = 4'(req); v.hwe = hwe; v.hdir = hdir; v.hch = 3'(hch); v.hval = 8'(hval);
    v.cwe = cwe; v.cdir = cdir; v.cch = 3'(cch); v.cval = 8'(cval);
    v.rdd = rdd; v.rdc = 3'(rdc); v.est = 2'(est);
    v.esm = esm; v.erm = erm; v.edb = edb; v.eerr = eerr;
    return v;
  endfunction

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    mk(2, 1,0,2,1, 0,0,0,0, 0,2,1, 7'h00,7'h00, 1,0), // R2 host posts NEW, R8 rings
    mk(2, 0,0,0,0, 1,0,2,2, 0,2,2, 7'h00,7'h00, 0,0), // R2 coprocessor RCVD
    mk(4, 0,0,0,0, 1,0,2,3, 0,2,3, 7'h04,7'h00, 0,0), // R4 COMPLETE sets bit 2
    mk(9, 1,0,2,0, 1,1,5,1, 1,5,1, 7'h00,7'h20, 0,0), // R9 host IDLE + coproc inbound NEW
    mk(5, 1,1,5,2, 0,0,0,0, 1,5,2, 7'h00,7'h00, 0,0), // R5 bit clears on RCVD
    mk(3, 1,1,5,3, 0,0,0,0, 1,5,3, 7'h00,7'h00, 1,0), // R3 host COMPLETE, R8 rings
    mk(3, 0,0,0,0, 1,1,5,0, 1,5,0, 7'h00,7'h00, 0,0), // R3 coprocessor back to IDLE
    mk(6, 1,0,0,9, 0,0,0,0, 0,0,0, 7'h00,7'h00, 0,0), // R6 value 9 ignored
    mk(6, 1,0,7,1, 1,1,7,1, 0,0,0, 7'h00,7'h00, 0,0), // R6 channel 7 ignored
    mk(9, 1,0,6,1, 1,1,1,1, 0,6,1, 7'h00,7'h02, 1,0), // R9 two posts at once
    mk(8, 1,1,1,2, 1,0,6,2, 0,6,2, 7'h00,7'h00, 0,0), // R8 host RCVD does not ring
    mk(7, 1,0,6,1, 0,0,0,0, 0,6,2, 7'h00,7'h00, 0,1)  // R7 NEW on non-IDLE rejected
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    h_we = 0; c_we = 0; h_dir = 0; c_dir = 0; h_ch = 0; c_ch = 0; h_val = 0; c_val = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      h_we = VEC[i].hwe; h_dir = VEC[i].hdir; h_ch = VEC[i].hch; h_val = VEC[i].hval;
      c_we = VEC[i].cwe; c_dir = VEC[i].cdir; c_ch = VEC[i].cch; c_val = VEC[i].cval;
      rd_dir = VEC[i].rdd; rd_ch = VEC[i].rdc;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i),
          {rd_state, send_done_map, recv_new_map, int_send, int_recv, doorbell, proto_err},
          {VEC[i].est, VEC[i].esm, VEC[i].erm, |VEC[i].esm, |VEC[i].erm, VEC[i].edb, VEC[i].eerr});
    end
    idle_inputs();
    @(negedge clk);
    chk("R8 doorbell one cycle", {31'd0, doorbell}, 32'd0);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_dir = 0; rd_ch = 6;
    @(negedge clk);
    chk("R1 reset state", {rd_state, send_done_map, recv_new_map, int_send, int_recv, doorbell, proto_err}, 32'd0);
    rd_dir = 1; rd_ch = 1;
    #0.1;
    chk("R1 inbound reset", {30'd0, rd_state}, 32'd0);

    c_we = 1; c_dir = 0; c_ch = 3; c_val = 1; rd_dir = 0; rd_ch = 3;
    @(negedge clk);
    chk("R7 wrong side state", {30'd0, rd_state}, 32'd0);
    chk("R7 wrong side err", {30'd0, doorbell, proto_err}, 32'd1);

    c_we = 0;
    h_we = 1; h_dir = 0; h_ch = 3; h_val = 1;
    @(posedge clk);
    #1;
    h_we = 0;
    chk("R10 visible after edge", {30'd0, rd_state}, 32'd1);
    @(negedge clk);
    chk("R7 sticky err", {31'd0, proto_err}, 32'd1);

    h_we = 1; h_dir = 0; h_ch = 3; h_val = 3;
    #0.1;
    chk("R10 not before edge", {30'd0, rd_state}, 32'd1);
    @(negedge clk);
    chk("R2 host COMPLETE from NEW refused", {30'd0, rd_state}, 32'd1);
    idle_inputs();
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule